// File: doc/BRIEF.md
# CEC Receive Frame Queue

This block sits behind the bit-level receiver of a CEC controller. Each cycle in which the receiver presents a complete frame, the block compares the frame's destination logical address with a 16-bit acceptance bitmap. A frame whose address is enabled enters a small queue of whole frames. Any other frame is thrown away. A frame that the receiver marks as errored still takes a queue slot, so software can see it and remove it.

Software sees only the frame at the head of the queue. It reads that frame through separate header, opcode and operand registers. One packed status byte gives the head frame's operand count, the number of frames waiting and the head frame's error flag. A control register removes the head frame or empties the whole queue. The bits written there act on the next clock and then return to zero. A sticky interrupt status register records frame arrivals and overflow drops and drives one interrupt line.

Top module: `cec_rx_frame_queue`

## Requirements
- R1: After reset the status byte, the header register, both bitmap registers, the control register and the interrupt status all read 0, and `irq` is low.
- R2: A presented frame is discarded, and the queue is left unchanged, when the bitmap bit indexed by header bits 3:0 is clear. The bitmap is written and read as two bytes: address 0x10 holds logical addresses 0 to 7 in bits 0 to 7, and address 0x14 holds addresses 8 to 15.
- R3: An accepted frame is appended to the queue. Bits 6:4 of the status byte (address 0x00) give the number of queued frames.
- R4: Bits 3:0 of the status byte give the head frame's operand count, limited to 14. Bit 7 gives the head frame's error flag. An empty queue reads 0.
- R5: The head frame's header reads at 0x04 and its opcode at 0x08. Operand k reads at 0x40 + 4k for k from 0 to 13. Operand slots at or past the operand count read 0, and every field reads 0 when the queue is empty.
- R6: Frames leave the queue in the order they arrived.
- R7: Writing a value with bit 0 set and bit 1 clear to the control register (0x0C) makes it read 1 for exactly one cycle. At the end of that cycle the head frame is removed and the register returns to 0. On an empty queue this has no effect.
- R8: Writing 3 to the control register makes it read 3 for one cycle. The queue is then emptied and the register returns to 0. An arriving frame in that execution cycle is also discarded.
- R9: The queue holds 4 frames. An accepted frame that arrives while 4 are queued is dropped and sets sticky bit 4 of the interrupt status (0x18).
- R10: A frame with its error flag set occupies one slot, shows bit 7 set while at the head, and is removed by a normal pop.
- R11: Each accepted frame sets bit 1 of the interrupt status. Writing 1 to a status bit clears it. `irq` is high while bit 1 or bit 4 is set.
- R12: Frames addressed to 15 are accepted only while bitmap bit 15 (bit 7 of 0x14) is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fr_valid | input | 1 | A complete frame is presented this cycle |
| fr_hdr | input | 8 | Header byte; bits 3:0 are the destination |
| fr_opc | input | 8 | Opcode byte |
| fr_opnd | input | 112 | Operand bytes, operand k in bits 8k+7:8k |
| fr_nopnd | input | 4 | Number of valid operands |
| fr_err | input | 1 | Receiver flagged the frame as errored |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| irq | output | 1 | Interrupt, high while a status bit is set |

## Verification
A stale read or write pointer shows up at the next header or operand read. A frame from the wrong position in the queue appears, or a popped frame appears a second time, and a scoreboard that follows arrival order catches this at once. A wrong occupancy count shows in bits 6:4 in the very cycle after the push or pop that caused it. It also decides whether the fifth frame is dropped. A control bit that does not clear by itself is visible one cycle after the write. It would also remove a second frame, which shows up as a wrong head frame and a wrong count.

// File: rtl/cec_rxq_pkg.sv
package cec_rxq_pkg;
    localparam int MAX_OPND = 14;
    localparam int LEN_W    = 4;

    typedef struct packed {
        logic                     err;
        logic [LEN_W-1:0]         nopnd;
        logic [MAX_OPND-1:0][7:0] opnd;
        logic [7:0]               opc;
        logic [7:0]               hdr;
    } rx_frame_t;

    localparam logic [7:0] A_COUNT   = 8'h00;
    localparam logic [7:0] A_HDR     = 8'h04;
    localparam logic [7:0] A_OPC     = 8'h08;
    localparam logic [7:0] A_CTRL    = 8'h0C;
    localparam logic [7:0] A_AMAP_LO = 8'h10;
    localparam logic [7:0] A_AMAP_HI = 8'h14;
    localparam logic [7:0] A_ISTAT   = 8'h18;
    localparam logic [7:0] A_OPND0   = 8'h40;
endpackage

// File: rtl/cec_rxq_filter.sv
module cec_rxq_filter
    import cec_rxq_pkg::*;
(
    input  logic                    valid,
    input  logic [7:0]              hdr,
    input  logic [7:0]              opc,
    input  logic [MAX_OPND*8-1:0]   opnd_flat,
    input  logic [LEN_W-1:0]        nopnd,
    input  logic                    err,
    input  logic [15:0]             amap,
    output logic                    hit,
    output rx_frame_t               frame
);
    // destination nibble selects one bit of the acceptance bitmap
    assign hit = valid & amap[hdr[3:0]];

    always_comb begin
        frame.hdr   = hdr;
        frame.opc   = opc;
        frame.opnd  = opnd_flat;
        frame.err   = err;
        frame.nopnd = (nopnd > LEN_W'(MAX_OPND)) ? LEN_W'(MAX_OPND) : nopnd;
    end
endmodule

// File: rtl/cec_rxq_store.sv
module cec_rxq_store
    import cec_rxq_pkg::*;
#(
    parameter  int DEPTH = 4,
    localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_req,
    input  rx_frame_t     push_frame,
    input  logic          pop,
    input  logic          flush,
    output rx_frame_t     front,
    output logic [CW-1:0] count,
    output logic          pushed,
    output logic          dropped
);
    typedef struct packed {
        logic [PW-1:0] wr;
        logic [PW-1:0] rd;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t      ptr_d, ptr_q;
    rx_frame_t mem_d [DEPTH];
    rx_frame_t mem_q [DEPTH];

    logic full;
    logic pop_eff;

    assign full    = (ptr_q.cnt == CW'(DEPTH));
    assign pushed  = push_req & ~full & ~flush;
    assign dropped = push_req & full & ~flush;
    assign pop_eff = pop & (ptr_q.cnt != '0) & ~flush;

    always_comb begin
        ptr_d = ptr_q;
        mem_d = mem_q;
        if (flush) begin
            ptr_d = '0;
        end else begin
            if (pushed) begin
                mem_d[ptr_q.wr] = push_frame;
                ptr_d.wr = (ptr_q.wr == PW'(DEPTH - 1)) ? '0 : ptr_q.wr + 1'b1;
            end
            if (pop_eff) begin
                ptr_d.rd = (ptr_q.rd == PW'(DEPTH - 1)) ? '0 : ptr_q.rd + 1'b1;
            end
            if (pushed && !pop_eff) begin
                ptr_d.cnt = ptr_q.cnt + CW'(1);
            end else if (!pushed && pop_eff) begin
                ptr_d.cnt = ptr_q.cnt - CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
            mem_q <= '{default: '0};
        end else begin
            ptr_q <= ptr_d;
            mem_q <= mem_d;
        end
    end

    assign front = (ptr_q.cnt != '0) ? mem_q[ptr_q.rd] : '0;
    assign count = ptr_q.cnt;

    p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q.cnt <= CW'(DEPTH));

    p_push_grows_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && !full && !flush && !pop) |=> (ptr_q.cnt == $past(ptr_q.cnt) + CW'(1)));

    p_full_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && full && !pop && !flush) |=> $stable(ptr_q.cnt));

    p_flush_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (ptr_q.cnt == '0));

    p_pop_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && ptr_q.cnt == '0 && !push_req) |=> $stable(ptr_q));
endmodule

// File: rtl/cec_rxq_regs.sv
module cec_rxq_regs
    import cec_rxq_pkg::*;
#(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [7:0]    reg_addr,
    input  logic [7:0]    reg_wdata,
    input  rx_frame_t     front,
    input  logic [CW-1:0] count,
    input  logic          pushed,
    input  logic          dropped,
    output logic [7:0]    reg_rdata,
    output logic [15:0]   amap,
    output logic          pop,
    output logic          flush,
    output logic          irq
);
    typedef struct packed {
        logic [15:0] amap;
        logic [1:0]  ctrl;
        logic        ne;
        logic        ovf;
    } regs_t;

    regs_t s_d, s_q;
    logic  wr_ctrl, wr_istat;

    assign wr_ctrl  = reg_wr && (reg_addr == A_CTRL);
    assign wr_istat = reg_wr && (reg_addr == A_ISTAT);

    always_comb begin
        s_d      = s_q;
        s_d.ctrl = 2'b00;          // a pending request executes this cycle
        if (wr_ctrl) begin
            if (reg_wdata[1:0] == 2'b11)
                s_d.ctrl = 2'b11;
            else if (reg_wdata[0])
                s_d.ctrl = 2'b01;
        end
        if (reg_wr && reg_addr == A_AMAP_LO) s_d.amap[7:0]  = reg_wdata;
        if (reg_wr && reg_addr == A_AMAP_HI) s_d.amap[15:8] = reg_wdata;
        if (wr_istat && reg_wdata[1]) s_d.ne  = 1'b0;
        if (wr_istat && reg_wdata[4]) s_d.ovf = 1'b0;
        if (pushed)  s_d.ne  = 1'b1;
        if (dropped) s_d.ovf = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign amap  = s_q.amap;
    assign pop   = (s_q.ctrl == 2'b01);
    assign flush = (s_q.ctrl == 2'b11);
    assign irq   = s_q.ne | s_q.ovf;

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_COUNT:   reg_rdata = {front.err, 3'(count), front.nopnd};
            A_HDR:     reg_rdata = front.hdr;
            A_OPC:     reg_rdata = front.opc;
            A_CTRL:    reg_rdata = {6'b0, s_q.ctrl};
            A_AMAP_LO: reg_rdata = s_q.amap[7:0];
            A_AMAP_HI: reg_rdata = s_q.amap[15:8];
            A_ISTAT:   reg_rdata = {3'b0, s_q.ovf, 2'b0, s_q.ne, 1'b0};
            default:   reg_rdata = '0;
        endcase
        for (int i = 0; i < MAX_OPND; i++) begin
            if (reg_addr == A_OPND0 + 8'(4 * i))
                reg_rdata = (LEN_W'(i) < front.nopnd) ? front.opnd[i] : 8'h00;
        end
    end

    p_ctrl_selfclear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ctrl != 2'b00 && !wr_ctrl) |=> (s_q.ctrl == 2'b00));

    p_ne_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
        pushed |=> (s_q.ne && irq));

    p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ovf && !(wr_istat && reg_wdata[4])) |=> s_q.ovf);

    p_ovf_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dropped |=> s_q.ovf);
endmodule

// File: rtl/cec_rx_frame_queue.sv
module cec_rx_frame_queue
    import cec_rxq_pkg::*;
#(
    parameter  int DEPTH = 4,               // at most 7: status field is 3 bits
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  fr_valid,
    input  logic [7:0]            fr_hdr,
    input  logic [7:0]            fr_opc,
    input  logic [MAX_OPND*8-1:0] fr_opnd,
    input  logic [LEN_W-1:0]      fr_nopnd,
    input  logic                  fr_err,
    input  logic                  reg_wr,
    input  logic [7:0]            reg_addr,
    input  logic [7:0]            reg_wdata,
    output logic [7:0]            reg_rdata,
    output logic                  irq
);
    logic [15:0]   amap;
    logic          hit;
    rx_frame_t     in_frame;
    rx_frame_t     front;
    logic [CW-1:0] count;
    logic          pop, flush, pushed, dropped;

    cec_rxq_filter u_filter (
        .valid     (fr_valid),
        .hdr       (fr_hdr),
        .opc       (fr_opc),
        .opnd_flat (fr_opnd),
        .nopnd     (fr_nopnd),
        .err       (fr_err),
        .amap      (amap),
        .hit       (hit),
        .frame     (in_frame)
    );

    cec_rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_req   (hit),
        .push_frame (in_frame),
        .pop        (pop),
        .flush      (flush),
        .front      (front),
        .count      (count),
        .pushed     (pushed),
        .dropped    (dropped)
    );

    cec_rxq_regs #(.CW(CW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .front     (front),
        .count     (count),
        .pushed    (pushed),
        .dropped   (dropped),
        .reg_rdata (reg_rdata),
        .amap      (amap),
        .pop       (pop),
        .flush     (flush),
        .irq       (irq)
    );

    p_filter_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_valid && !hit && !pop && !flush) |=> $stable(count));
endmodule

// File: tb/cec_rx_frame_queue_tb_top.sv
`timescale 1ns/1ps
module cec_rx_frame_queue_tb_top;
    import cec_rxq_pkg::*;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  fr_valid = 1'b0;
    logic [7:0]            fr_hdr = '0;
    logic [7:0]            fr_opc = '0;
    logic [MAX_OPND*8-1:0] fr_opnd = '0;
    logic [LEN_W-1:0]      fr_nopnd = '0;
    logic                  fr_err = 1'b0;
    logic                  reg_wr = 1'b0;
    logic [7:0]            reg_addr = '0;
    logic [7:0]            reg_wdata = '0;
    logic [7:0]            reg_rdata;
    logic                  irq;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    typedef struct {
        logic [7:0] hdr;
        logic [7:0] opc;
        logic [7:0] op [MAX_OPND];
        int         n;
        logic       err;
    } exp_t;

    exp_t        sb [$];
    logic [15:0] m_amap = '0;

    always #4 clk = ~clk;

    cec_rx_frame_queue dut_i (
        .clk, .rst_n, .fr_valid, .fr_hdr, .fr_opc, .fr_opnd, .fr_nopnd,
        .fr_err, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata, .irq
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [7:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    // driver: presents one frame and records what the queue should hold
    task automatic send(input logic [7:0] hdr, input logic [7:0] opc,
                        input int n, input logic err, input int seed);
        exp_t e;
        e.hdr = hdr; e.opc = opc; e.err = err;
        e.n = (n > MAX_OPND) ? MAX_OPND : n;
        for (int i = 0; i < MAX_OPND; i++) begin
            e.op[i] = 8'(seed * 17 + i * 5 + 3);
            fr_opnd[i*8 +: 8] = e.op[i];
        end
        fr_hdr = hdr; fr_opc = opc; fr_nopnd = 4'(n); fr_err = err;
        fr_valid = 1'b1;
        @(negedge clk);
        fr_valid = 1'b0;
        if (m_amap[hdr[3:0]] && sb.size() < 4) sb.push_back(e);
    endtask

    // monitor: compares the head frame with the scoreboard, then pops both
    task automatic check_front();
        exp_t e;
        logic [7:0] v;
        int qn;
        e  = sb[0];
        qn = sb.size();
        reg_read(A_COUNT, v);
        chk("R4 status byte", v, {e.err, 3'(qn), 4'(e.n)});
        reg_read(A_HDR, v); chk("R6 header order", v, e.hdr);
        reg_read(A_OPC, v); chk("R5 opcode", v, e.opc);
        for (int i = 0; i < MAX_OPND; i++) begin
            reg_read(A_OPND0 + 8'(4 * i), v);
            chk("R5 operand slot", v, (i < e.n) ? e.op[i] : 0);
        end
        reg_write(A_CTRL, 8'h01);
        reg_read(A_CTRL, v); chk("R7 pop bit pending", v, 1);
        @(negedge clk);
        reg_read(A_CTRL, v); chk("R7 pop bit cleared", v, 0);
        reg_read(A_COUNT, v); chk("R7 count after pop", (v >> 4) & 7, qn - 1);
        void'(sb.pop_front());
    endtask

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        reg_read(A_COUNT, v);   chk("R1 status", v, 0);
        reg_read(A_HDR, v);     chk("R1 header", v, 0);
        reg_read(A_AMAP_LO, v); chk("R1 bitmap lo", v, 0);
        reg_read(A_AMAP_HI, v); chk("R1 bitmap hi", v, 0);
        reg_read(A_CTRL, v);    chk("R1 control", v, 0);
        reg_read(A_ISTAT, v);   chk("R1 istat", v, 0);
        chk("R1 irq", irq, 0);

        send(8'h04, 8'h11, 2, 1'b0, 9);
        reg_read(A_COUNT, v); chk("R2 empty bitmap drops", v, 0);
        chk("R2 no irq", irq, 0);

        reg_write(A_AMAP_LO, 8'h10); m_amap[7:0] = 8'h10;
        reg_read(A_AMAP_LO, v); chk("R2 bitmap readback", v, 8'h10);
        send(8'h34, 8'h82, 3, 1'b0, 1);
        reg_read(A_COUNT, v); chk("R3 one frame queued", v, 8'h13);
        reg_read(A_ISTAT, v); chk("R11 not-empty bit", v, 8'h02);
        chk("R11 irq high", irq, 1);
        reg_write(A_ISTAT, 8'h02);
        reg_read(A_ISTAT, v); chk("R11 w1c clears", v, 0);
        chk("R11 irq low", irq, 0);

        send(8'h35, 8'h44, 1, 1'b0, 2);
        reg_read(A_COUNT, v); chk("R2 unlisted address dropped", v, 8'h13);
        send(8'h4F, 8'h36, 2, 1'b0, 3);
        reg_read(A_COUNT, v); chk("R12 broadcast blocked", v, 8'h13);
        reg_write(A_AMAP_HI, 8'h80); m_amap[15:8] = 8'h80;
        send(8'h4F, 8'h36, 2, 1'b0, 4);
        reg_read(A_COUNT, v); chk("R12 broadcast accepted", (v >> 4) & 7, 2);

        check_front();
        check_front();

        reg_write(A_CTRL, 8'h01);
        @(negedge clk);
        reg_read(A_COUNT, v); chk("R7 pop on empty", v, 0);
        reg_read(A_HDR, v);   chk("R5 empty header", v, 0);

        send(8'h24, 8'h9A, 0, 1'b1, 5);
        send(8'h1F, 8'h70, 15, 1'b0, 6);
        send(8'h04, 8'h05, 1, 1'b0, 7);
        send(8'h54, 8'hC3, 5, 1'b0, 8);
        reg_read(A_ISTAT, v); chk("R9 no overflow yet", v & 8'h10, 0);
        send(8'h04, 8'hEE, 4, 1'b0, 10);
        reg_read(A_COUNT, v); chk("R9 queue stays full", (v >> 4) & 7, 4);
        chk("R10 errored head flag", v[7], 1);
        reg_read(A_ISTAT, v); chk("R9 overflow sticky", v, 8'h12);
        @(negedge clk);
        reg_read(A_ISTAT, v); chk("R9 overflow holds", v & 8'h10, 8'h10);
        reg_write(A_ISTAT, 8'h12);
        chk("R11 irq cleared", irq, 0);
        for (int k = 0; k < 4; k++) check_front();  // R10 R4 R6

        send(8'h04, 8'h01, 1, 1'b0, 11);
        send(8'h04, 8'h02, 2, 1'b0, 12);
        send(8'h04, 8'h03, 3, 1'b0, 13);
        reg_write(A_CTRL, 8'h03);
        reg_read(A_CTRL, v); chk("R8 flush bits pending", v, 3);
        @(negedge clk);
        reg_read(A_CTRL, v);  chk("R8 flush bits cleared", v, 0);
        reg_read(A_COUNT, v); chk("R8 queue emptied", v, 0);
        sb.delete();
        send(8'h04, 8'h5A, 2, 1'b0, 14);
        check_front();  // R8 queue usable after flush

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule